// File: doc/BRIEF.md
# Display RAM write address sequencer

This block sits between a display controller's command decoder and its banked display memory. For every data byte that the host writes, it produces the physical RAM address to store it at, the byte itself (straight or with its bit order reversed) and a single-cycle write enable. It then moves its logical column and bank pointers on to the next cell.

The memory holds 128 columns by 13 byte-wide banks. The pointers advance along columns (horizontal order) or along banks (vertical order). They wrap at programmable column and bank carriage limits, so a window narrower than the full array can be filled by a continuous stream of bytes. A mirror mode flips which physical edge logical column 0 sits on without changing how the pointers move. Explicit load commands place either pointer anywhere inside the carriage window.

Top module: `dram_wr_seq`

## Requirements
- R1: While reset is asserted and in the cycle after its release, `ram_we` is 0 and both logical pointers `cur_x` and `cur_y` read 0.
- R2: A cycle with `wr_stb` high and no load command produces `ram_we` = 1 in exactly the next cycle. In that cycle `ram_addr` = bank × 128 + physical column, that is `{bank[3:0], column[6:0]}`, for the pointer value held when the strobe was sampled. Strobes on consecutive cycles give `ram_we` on consecutive cycles, and `ram_we` is 0 in every cycle not preceded by a strobe.
- R3: With `mode_vert` = 0, each byte increments `cur_x`. A byte written at `cur_x` ≥ the column limit sets `cur_x` to 0 and moves `cur_y` to the next bank.
- R4: With `mode_vert` = 1, each byte increments `cur_y`. A byte written at `cur_y` ≥ the bank limit sets `cur_y` to 0 and moves `cur_x` to the next column.
- R5: A byte written with both pointers at or above their limits returns the pointers to (0,0) in both orders.
- R6: With `mode_mirror` = 1 the physical column is 127 − `cur_x`. With `mode_mirror` = 0 it equals `cur_x`. Pointer movement is the same in both cases.
- R7: With `mode_flip` = 1, `ram_wdata` bit i equals `wr_data` bit 7−i. With `mode_flip` = 0, `ram_wdata` equals `wr_data`.
- R8: `ld_x` sets `cur_x` to min(`ld_x_val`, `xlim`), and `ld_y` sets `cur_y` to min(`ld_y_val`, bank limit). A pointer that is not loaded holds. A strobe in the same cycle as a load is written at the old pointers, and its advance is suppressed.
- R9: A `ylim` above 12 acts as a bank limit of 12, so the pointers never leave banks 0 to 12.
- R10: Limits and mode bits are taken in the cycle the strobe is sampled. A mode change applied between two bytes affects only the later byte, including on back-to-back strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One data byte accepted this cycle |
| wr_data | input | 8 | Data byte |
| ld_x | input | 1 | Load column pointer |
| ld_x_val | input | 7 | Column value to load |
| ld_y | input | 1 | Load bank pointer |
| ld_y_val | input | 4 | Bank value to load |
| xlim | input | 7 | Column carriage limit |
| ylim | input | 4 | Bank carriage limit (values above 12 act as 12) |
| mode_mirror | input | 1 | Logical column 0 on the right edge |
| mode_vert | input | 1 | Advance banks first |
| mode_flip | input | 1 | Reverse bit order of each byte |
| ram_addr | output | 11 | Physical RAM address {bank, column} |
| ram_wdata | output | 8 | Byte to store |
| ram_we | output | 1 | Write enable, one cycle per byte |
| cur_x | output | 7 | Logical column pointer |
| cur_y | output | 4 | Logical bank pointer |

## Verification
The hardest case to reach is the double carriage, where one byte lands on the last column and the last bank together. In vertical order this happens only after a whole window of columns has been filled. The bench reaches it by shrinking both limits to a few cells and streaming enough bytes to pass the corner in each order. It reaches the bank overflow case by setting the bank limit above 12 with a column limit of 0, so that thirteen bytes walk every bank. Back-to-back strobes with a mode change between them cover the per-byte sampling of the mode bits.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  localparam int COLS  = 128;
  localparam int BANKS = 13;
  localparam int DW    = 8;
  localparam int XW    = $clog2(COLS);
  localparam int YW    = $clog2(BANKS);
  localparam int AW    = XW + YW;

  typedef logic [XW-1:0] col_t;
  typedef logic [YW-1:0] bank_t;
  typedef logic [DW-1:0] byte_t;
  typedef logic [AW-1:0] addr_t;

  typedef struct packed {
    col_t  x;
    bank_t y;
  } ptr_t;

  typedef struct packed {
    logic mirror;
    logic vert;
    logic flip;
  } mode_t;

  localparam col_t  COL_LAST  = col_t'(COLS - 1);
  localparam bank_t BANK_LAST = bank_t'(BANKS - 1);

  function automatic bank_t bank_cap(bank_t v);
    return (v > BANK_LAST) ? BANK_LAST : v;
  endfunction

  function automatic col_t col_min(col_t a, col_t b);
    return (a > b) ? b : a;
  endfunction

  function automatic bank_t bank_min(bank_t a, bank_t b);
    return (a > b) ? b : a;
  endfunction

  function automatic col_t phys_col(col_t x, logic mirror);
    return mirror ? (COL_LAST - x) : x;
  endfunction

  function automatic byte_t bit_order(byte_t d, logic flip);
    byte_t r;
    for (int i = 0; i < DW; i++) r[i] = d[DW-1-i];
    return flip ? r : d;
  endfunction

  function automatic addr_t make_addr(bank_t y, col_t c);
    return {y, c};
  endfunction
endpackage

// File: rtl/seq_limits.sv
module seq_limits
  import dram_seq_pkg::*;
(
  input  col_t  xlim_in,
  input  bank_t ylim_in,
  output col_t  xlim_eff,
  output bank_t ylim_eff
);
  assign xlim_eff = xlim_in;
  assign ylim_eff = bank_cap(ylim_in);
endmodule

// File: rtl/seq_ptr_next.sv
module seq_ptr_next
  import dram_seq_pkg::*;
(
  input  ptr_t  cur,
  input  col_t  xl,
  input  bank_t yl,
  input  logic  vert,
  input  logic  adv,
  input  logic  ldx,
  input  col_t  ldx_val,
  input  logic  ldy,
  input  bank_t ldy_val,
  output ptr_t  nxt,
  output logic  corner
);
  logic x_end, y_end;
  ptr_t stepped;

  assign x_end  = (cur.x >= xl);
  assign y_end  = (cur.y >= yl);
  assign corner = adv && !ldx && !ldy && x_end && y_end;

  always_comb begin
    stepped = cur;
    if (!vert) begin
      if (x_end) begin
        stepped.x = '0;
        stepped.y = y_end ? '0 : cur.y + bank_t'(1);
      end else begin
        stepped.x = cur.x + col_t'(1);
      end
    end else begin
      if (y_end) begin
        stepped.y = '0;
        stepped.x = x_end ? '0 : cur.x + col_t'(1);
      end else begin
        stepped.y = cur.y + bank_t'(1);
      end
    end
  end

  always_comb begin
    nxt = cur;
    if (ldx || ldy) begin
      if (ldx) nxt.x = col_min(ldx_val, xl);
      if (ldy) nxt.y = bank_min(ldy_val, yl);
    end else if (adv) begin
      nxt = stepped;
    end
  end
endmodule

// File: rtl/seq_out_map.sv
module seq_out_map
  import dram_seq_pkg::*;
(
  input  ptr_t  cur,
  input  mode_t mode,
  input  byte_t din,
  output addr_t addr,
  output byte_t dout
);
  assign addr = make_addr(cur.y, phys_col(cur.x, mode.mirror));
  assign dout = bit_order(din, mode.flip);
endmodule

// File: rtl/dram_wr_seq.sv
module dram_wr_seq
  import dram_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          ld_x,
  input  logic [XW-1:0] ld_x_val,
  input  logic          ld_y,
  input  logic [YW-1:0] ld_y_val,
  input  logic [XW-1:0] xlim,
  input  logic [YW-1:0] ylim,
  input  logic          mode_mirror,
  input  logic          mode_vert,
  input  logic          mode_flip,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_we,
  output logic [XW-1:0] cur_x,
  output logic [YW-1:0] cur_y
);
  ptr_t  ptr_q, ptr_d;
  col_t  xl_eff;
  bank_t yl_eff;
  mode_t mode_now;
  addr_t addr_c;
  byte_t data_c;
  logic  wrap_all;
  logic  load_fire;
  logic  adv_fire;

  assign mode_now  = '{mirror: mode_mirror, vert: mode_vert, flip: mode_flip};
  assign load_fire = ld_x || ld_y;
  assign adv_fire  = wr_stb && !load_fire;

  seq_limits u_lim (
    .xlim_in (xlim),
    .ylim_in (ylim),
    .xlim_eff(xl_eff),
    .ylim_eff(yl_eff)
  );

  seq_ptr_next u_nxt (
    .cur    (ptr_q),
    .xl     (xl_eff),
    .yl     (yl_eff),
    .vert   (mode_now.vert),
    .adv    (wr_stb),
    .ldx    (ld_x),
    .ldx_val(ld_x_val),
    .ldy    (ld_y),
    .ldy_val(ld_y_val),
    .nxt    (ptr_d),
    .corner (wrap_all)
  );

  seq_out_map u_map (
    .cur (ptr_q),
    .mode(mode_now),
    .din (wr_data),
    .addr(addr_c),
    .dout(data_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ptr_q  <= ptr_d;
      ram_we <= wr_stb;
      if (wr_stb) begin
        ram_addr  <= addr_c;
        ram_wdata <= data_c;
      end
    end
  end

  assign cur_x = ptr_q.x;
  assign cur_y = ptr_q.y;
endmodule

// File: rtl/dram_wr_seq_chk.sv
module dram_wr_seq_chk
  import dram_seq_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_stb,
  input logic [DW-1:0] wr_data,
  input logic          ld_x,
  input logic [XW-1:0] xlim,
  input logic          ld_y,
  input logic [YW-1:0] ylim,
  input logic          mode_mirror,
  input logic          mode_vert,
  input logic          mode_flip,
  input logic [AW-1:0] ram_addr,
  input logic [DW-1:0] ram_wdata,
  input logic          ram_we,
  input logic [XW-1:0] cur_x,
  input logic [YW-1:0] cur_y,
  input logic          wrap_all,
  input logic          adv_fire
);
  assert_we_follows_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> ram_we);
  assert_we_only_after_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> !ram_we);
  assert_horiz_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_fire && !mode_vert && cur_x < xlim) |=>
      (cur_x == $past(cur_x) + 7'd1) && (cur_y == $past(cur_y)));
  assert_vert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_fire && mode_vert && cur_y < ylim && cur_y < 4'd12) |=>
      (cur_y == $past(cur_y) + 4'd1) && (cur_x == $past(cur_x)));
  assert_corner_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_all |=> (cur_x == '0) && (cur_y == '0));
  assert_mirror_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && mode_mirror) |=> (ram_addr[XW-1:0] == 7'd127 - $past(cur_x)));
  assert_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && mode_flip) |=> (ram_wdata[0] == $past(wr_data[7])) && (ram_wdata[7] == $past(wr_data[0])));
  assert_load_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_x |=> (cur_x <= $past(xlim)));
  assert_load_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_x && !ld_y) |=> (cur_y == $past(cur_y)));
  assert_bank_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cur_y <= 4'd12);
endmodule

bind dram_wr_seq dram_wr_seq_chk i_chk (.*);

// File: tb/test_dram_wr_seq.sv
module test_dram_wr_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ld_x = 1'b0, ld_y = 1'b0;
  logic [6:0] ld_x_val = '0;
  logic [3:0] ld_y_val = '0;
  logic [6:0] xlim = 7'd127;
  logic [3:0] ylim = 4'd12;
  logic       mode_mirror = 1'b0, mode_vert = 1'b0, mode_flip = 1'b0;
  logic [10:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic        ram_we;
  logic [6:0]  cur_x;
  logic [3:0]  cur_y;

  int tests = 0, fails = 0;
  int mx = 0, my = 0;

  always #4 clk = ~clk;

  dram_wr_seq i_dram_wr_seq (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .ld_x(ld_x), .ld_x_val(ld_x_val), .ld_y(ld_y), .ld_y_val(ld_y_val),
    .xlim(xlim), .ylim(ylim), .mode_mirror(mode_mirror), .mode_vert(mode_vert),
    .mode_flip(mode_flip), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .cur_x(cur_x), .cur_y(cur_y)
  );

  task automatic chk(string req, string what, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int rev8(int d, bit f);
    int r = 0;
    if (!f) return d;
    for (int i = 0; i < 8; i++) if (d[i]) r += (1 << (7 - i));
    return r;
  endfunction

  function automatic int ycap();
    return (int'(ylim) > 12) ? 12 : int'(ylim);
  endfunction

  // advance the bench's pointer model by one byte
  task automatic model_step();
    int xl = int'(xlim), yl = ycap();
    if (!mode_vert) begin
      if (mx < xl) mx++;
      else begin mx = 0; my = (my < yl) ? my + 1 : 0; end
    end else begin
      if (my < yl) my++;
      else begin my = 0; mx = (mx < xl) ? mx + 1 : 0; end
    end
  endtask

  // starts and ends at a falling edge; consecutive calls give back-to-back strobes
  task automatic wr_byte(string req, int d);
    int col, exp_a, exp_d;
    col = mode_mirror ? 127 - mx : mx;
    exp_a = my * 128 + col;
    exp_d = rev8(d, mode_flip);
    wr_stb = 1'b1; wr_data = 8'(d);
    @(negedge clk);
    wr_stb = 1'b0;
    model_step();
    chk(req, "we", int'(ram_we), 1);
    chk(req, "addr", int'(ram_addr), exp_a);
    chk(req, "data", int'(ram_wdata), exp_d);
    chk(req, "cur_x", int'(cur_x), mx);
    chk(req, "cur_y", int'(cur_y), my);
  endtask

  task automatic idle_check(string req);
    @(negedge clk);
    chk(req, "we idle", int'(ram_we), 0);
  endtask

  task automatic load(bit lx, int vx, bit ly, int vy);
    ld_x = lx; ld_x_val = 7'(vx); ld_y = ly; ld_y_val = 4'(vy);
    @(negedge clk);
    ld_x = 1'b0; ld_y = 1'b0;
    if (lx) mx = (vx > int'(xlim)) ? int'(xlim) : vx;
    if (ly) my = (vy > ycap()) ? ycap() : vy;
  endtask

  task automatic t_reset();
    chk("R1", "we", int'(ram_we), 0);
    chk("R1", "cur_x", int'(cur_x), 0);
    chk("R1", "cur_y", int'(cur_y), 0);
  endtask

  task automatic t_horiz();
    xlim = 7'd3; ylim = 4'd2; mode_vert = 0; mode_mirror = 0; mode_flip = 0;
    load(1, 0, 1, 0);
    for (int i = 0; i < 14; i++) wr_byte("R3/R5", 16 + i);
    chk("R5", "horiz wrapped x", int'(cur_x), 2);
    chk("R5", "horiz wrapped y", int'(cur_y), 0);
    idle_check("R2");
  endtask

  task automatic t_vert();
    xlim = 7'd2; ylim = 4'd3; mode_vert = 1;
    load(1, 0, 1, 0);
    for (int i = 0; i < 13; i++) wr_byte("R4/R5", 40 + i);
    chk("R5", "vert wrapped x", int'(cur_x), 0);
    chk("R5", "vert wrapped y", int'(cur_y), 1);
    idle_check("R2");
  endtask

  task automatic t_mirror();
    xlim = 7'd127; ylim = 4'd12; mode_vert = 0; mode_mirror = 1;
    load(1, 5, 1, 3);
    wr_byte("R6", 8'h11);
    chk("R6", "col 5 mirrored", int'(ram_addr[6:0]), 122);
    load(1, 0, 0, 0);
    wr_byte("R6", 8'h22);
    chk("R6", "col 0 mirrored", int'(ram_addr[6:0]), 127);
    load(1, 127, 0, 0);
    wr_byte("R6", 8'h33);
    chk("R6", "col 127 mirrored", int'(ram_addr[6:0]), 0);
    mode_mirror = 0;
    idle_check("R2");
  endtask

  task automatic t_flip();
    mode_flip = 1;
    wr_byte("R7", 8'h01);
    chk("R7", "flip 01", int'(ram_wdata), 8'h80);
    wr_byte("R7", 8'hA3);
    chk("R7", "flip A3", int'(ram_wdata), 8'hC5);
    mode_flip = 0;
    wr_byte("R7", 8'hA3);
    chk("R7", "straight A3", int'(ram_wdata), 8'hA3);
    idle_check("R2");
  endtask

  task automatic t_load();
    int ox, oy;
    xlim = 7'd10; ylim = 4'd5; mode_vert = 0;
    load(1, 50, 0, 0);
    chk("R8", "x clamped", int'(cur_x), 10);
    load(0, 0, 1, 9);
    chk("R8", "y clamped", int'(cur_y), 5);
    chk("R8", "x held", int'(cur_x), 10);
    load(1, 4, 1, 2);
    ox = mx; oy = my;
    // strobe together with a load: written at old pointer, no advance
    wr_stb = 1; wr_data = 8'h5A; ld_x = 1; ld_x_val = 7'd7;
    @(negedge clk);
    wr_stb = 0; ld_x = 0;
    chk("R8", "we with load", int'(ram_we), 1);
    chk("R8", "addr old ptr", int'(ram_addr), oy * 128 + ox);
    chk("R8", "x loaded", int'(cur_x), 7);
    chk("R8", "y not advanced", int'(cur_y), oy);
    mx = 7;
    idle_check("R2");
  endtask

  task automatic t_ybig();
    xlim = 7'd0; ylim = 4'd15; mode_vert = 0;
    load(1, 0, 1, 0);
    for (int i = 0; i < 13; i++) wr_byte("R9", i);
    chk("R9", "banks wrapped", int'(cur_y), 0);
    chk("R9", "last bank addr", int'(ram_addr), 12 * 128);
    idle_check("R2");
  endtask

  task automatic t_mode_change();
    xlim = 7'd127; ylim = 4'd12; mode_vert = 0;
    load(1, 20, 1, 1);
    wr_byte("R10", 8'h01);
    mode_vert = 1; mode_flip = 1;   // applied between back-to-back strobes
    wr_byte("R10", 8'h02);
    chk("R10", "vert after change x", int'(cur_x), 21);
    chk("R10", "vert after change y", int'(cur_y), 2);
    mode_vert = 0; mode_flip = 0;
    idle_check("R10");
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "we in reset", int'(ram_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_horiz();
    t_vert();
    t_mirror();
    t_flip();
    t_load();
    t_ybig();
    t_mode_change();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule